// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block carries received Ethernet-style frames from a byte stream into host memory through a ring of descriptors. Each descriptor is two 32-bit words. The first is a control/status word. The second is the byte address of a receive buffer. The host hands a descriptor to the engine by setting the ownership bit in the control word. The engine keeps a snapshot of the current descriptor, refreshing it by polling whenever no frame is in flight.

When a frame starts on a descriptor the engine owns, each byte is stored into the buffer. At frame end the engine writes back a status word. That word clears ownership and holds the frame length and segment flags, plus the error and address-match flags; the match flags arrive as sideband inputs. It also raises a receive-OK or receive-error request and moves to the next descriptor, wrapping at the end-of-ring mark.

A frame that starts while the current descriptor is not owned by the engine is dropped whole. The engine raises a descriptor-unavailable request and counts the frame as missed. Frames longer than the programmed maximum are cut short and flagged.

Top module: `rx_desc_ring_engine`

## Requirements
- R1: While reset is held and right after it, no memory write is issued, all interrupt request bits are 0 and the missed-frame count is 0.
- R2: When idle, the engine reads the control word at ring_base + 8*index and then the buffer address at ring_base + 8*index + 4. Memory read data is returned one cycle after the request. Index starts at 0.
- R3: Byte k of an accepted frame is written to byte address buffer + k. The write uses the word-aligned address, a one-hot byte enable selecting lane (buffer + k) mod 4, and the byte replicated on all four lanes.
- R4: At frame end the control word is overwritten with a status word. In that word, bit 31 (ownership) = 0, bit 29 (first segment) = 1, bit 28 (last segment) = 1, and bits 13:0 hold the stored byte count, which includes the 4 CRC bytes.
- R5: Bit 30 (end of ring) of the used descriptor is kept in the status word. After a descriptor with bit 30 set, the next descriptor is index 0; otherwise it is index + 1.
- R6: Status bit 19 copies the CRC error marker given with the last byte. Bit 20 (runt) is set when the frame has fewer than RUNT_LEN (64) bytes. Bit 23 is set if the FIFO-overflow marker was seen on any byte. Bit 21 is the OR of bits 19, 20, 23 and 24.
- R7: Status bits 25 (broadcast), 26 (own-address match) and 27 (multicast) copy the sideband inputs present with the last byte.
- R8: Bytes beyond max_len are not written. The length field then reads max_len and bit 24 (buffer overflow) is set. A frame of exactly max_len bytes is stored whole without bit 24.
- R9: In the write-back cycle, irq_req bit 0 (receive OK) pulses for one cycle when status bit 21 is 0, and irq_req bit 1 (receive error) pulses when it is 1.
- R10: A frame starting while the current descriptor is not owned causes no memory write and no write-back. It pulses irq_req bit 4 once, adds 1 to missed_cnt, and leaves the index unchanged.
- R11: Once the host sets ownership on that descriptor, the next frame is stored into it through polling alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of descriptor 0 |
| max_len | input | 16 | Maximum bytes stored per frame |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_crc_err | input | 1 | CRC error, valid with rx_eof |
| rx_fifo_ovf | input | 1 | Upstream FIFO overflow marker, any byte |
| rx_bcast | input | 1 | Broadcast destination, valid with rx_eof |
| rx_phys_match | input | 1 | Own-address match, valid with rx_eof |
| rx_mcast | input | 1 | Multicast destination, valid with rx_eof |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Read byte address (word aligned) |
| mem_rd_data | input | 32 | Read data, one cycle after request |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | AW | Write byte address (word aligned) |
| mem_wr_be | output | 4 | Byte enables |
| mem_wr_data | output | 32 | Write data |
| irq_req | output | 16 | Interrupt request pulses (bits 0, 1, 4 used) |
| missed_cnt | output | MW | Saturating count of dropped frames |

## Verification
The bench goes after the runt boundary with frames of 63 and 64 bytes. A design that compared with the wrong sign or an off-by-one would flag the good frame or pass the short one. It checks truncation at max_len + 20 and at exactly max_len. A wrong bound would write one byte too many over the fill pattern or set buffer overflow on a frame that fits. It walks the ring twice to prove the wrap after the end-of-ring descriptor, which a design that ignored bit 30 would miss by writing past the ring. It then withholds one descriptor: a design that stored the frame anyway, advanced the index, or skipped the unavailable pulse shows up in memory, in the missed count, or in the placement of the following frame.

// File: rtl/rde_pkg.sv
package rde_pkg;
  localparam int ST_OWN  = 31;
  localparam int ST_EOR  = 30;
  localparam int ST_FS   = 29;
  localparam int ST_LS   = 28;
  localparam int ST_MC   = 27;
  localparam int ST_PAM  = 26;
  localparam int ST_BC   = 25;
  localparam int ST_BOVF = 24;
  localparam int ST_FOVF = 23;
  localparam int ST_RES  = 21;
  localparam int ST_RUNT = 20;
  localparam int ST_CRC  = 19;
  localparam int LEN_W   = 14;

  localparam int IRQ_ROK = 0;
  localparam int IRQ_RER = 1;
  localparam int IRQ_RDU = 4;

  typedef enum logic [2:0] {
    S_POLL_CTL, S_POLL_BUF, S_POLL_DONE, S_FRAME, S_DROP, S_WB
  } rde_state_e;

  typedef struct packed {
    logic mc;
    logic pam;
    logic bc;
    logic bovf;
    logic fovf;
    logic runt;
    logic crc;
  } rde_flags_t;

  function automatic logic err_summary(rde_flags_t f);
    return f.crc | f.runt | f.fovf | f.bovf;
  endfunction

  function automatic logic [31:0] pack_status(logic eor, rde_flags_t f, logic [15:0] len);
    logic [31:0] w;
    w = '0;
    w[ST_OWN]  = 1'b0;
    w[ST_EOR]  = eor;
    w[ST_FS]   = 1'b1;
    w[ST_LS]   = 1'b1;
    w[ST_MC]   = f.mc;
    w[ST_PAM]  = f.pam;
    w[ST_BC]   = f.bc;
    w[ST_BOVF] = f.bovf;
    w[ST_FOVF] = f.fovf;
    w[ST_RES]  = err_summary(f);
    w[ST_RUNT] = f.runt;
    w[ST_CRC]  = f.crc;
    w[LEN_W-1:0] = len[LEN_W-1:0];
    return w;
  endfunction

  function automatic logic [15:0] sat_inc16(logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction
endpackage

// File: rtl/rde_ring_ptr.sv
module rde_ring_ptr #(
  parameter int AW        = 32,
  parameter int MAX_DESC  = 1024,
  parameter int IDX_W     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic [31:0]   rd_data,
  input  logic          cap_ctl,
  input  logic          commit,
  input  logic          advance,
  input  logic          adv_eor,
  output logic [AW-1:0] desc_addr,
  output logic          snap_vld,
  output logic          snap_own,
  output logic          snap_eor,
  output logic [AW-1:0] snap_buf
);
  import rde_pkg::*;

  logic [IDX_W-1:0] idx_q;
  logic             own_tmp_q, eor_tmp_q;

  assign desc_addr = ring_base + AW'({idx_q, 3'b000});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      own_tmp_q <= 1'b0;
      eor_tmp_q <= 1'b0;
      snap_vld  <= 1'b0;
      snap_own  <= 1'b0;
      snap_eor  <= 1'b0;
      snap_buf  <= '0;
    end else begin
      if (cap_ctl) begin
        own_tmp_q <= rd_data[ST_OWN];
        eor_tmp_q <= rd_data[ST_EOR];
      end
      if (commit) begin
        snap_own <= own_tmp_q;
        snap_eor <= eor_tmp_q;
        snap_buf <= rd_data[AW-1:0];
        snap_vld <= 1'b1;
      end
      if (advance) begin
        snap_vld <= 1'b0;
        if (adv_eor || idx_q == IDX_W'(MAX_DESC - 1)) idx_q <= '0;
        else                                           idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  // R5: moving to a new descriptor discards the old snapshot
  p_adv_invalidates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> !snap_vld);
endmodule

// File: rtl/rde_frame_track.sv
module rde_frame_track #(
  parameter int AW       = 32,
  parameter int RUNT_LEN = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          byte_en,
  input  logic          eof,
  input  logic [AW-1:0] snap_buf,
  input  logic          snap_eor,
  input  logic [15:0]   max_len,
  input  logic          rx_fifo_ovf,
  input  logic          rx_crc_err,
  input  logic          rx_bcast,
  input  logic          rx_phys_match,
  input  logic          rx_mcast,
  output logic          store_en,
  output logic [AW-1:0] store_addr,
  output logic          frm_eor,
  output logic [31:0]   status_word,
  output logic          status_err
);
  import rde_pkg::*;

  logic [15:0]   cnt_q;
  logic [AW-1:0] base_q;
  logic          fovf_q;
  logic [15:0]   cur_cnt, total, stored;
  logic [AW-1:0] cur_base;
  logic          cur_fovf;
  rde_flags_t    flags;

  assign cur_cnt    = start ? 16'd0 : cnt_q;
  assign cur_base   = start ? snap_buf : base_q;
  assign cur_fovf   = (!start && fovf_q) | rx_fifo_ovf;
  assign total      = sat_inc16(cur_cnt);
  assign stored     = (total > max_len) ? max_len : total;
  assign store_en   = byte_en && (cur_cnt < max_len);
  assign store_addr = cur_base + AW'(cur_cnt);

  always_comb begin
    flags      = '0;
    flags.crc  = rx_crc_err;
    flags.runt = total < 16'(RUNT_LEN);
    flags.fovf = cur_fovf;
    flags.bovf = total > max_len;
    flags.bc   = rx_bcast;
    flags.pam  = rx_phys_match;
    flags.mc   = rx_mcast;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      base_q      <= '0;
      fovf_q      <= 1'b0;
      frm_eor     <= 1'b0;
      status_word <= '0;
      status_err  <= 1'b0;
    end else if (byte_en) begin
      cnt_q  <= total;
      fovf_q <= cur_fovf;
      if (start) begin
        base_q  <= snap_buf;
        frm_eor <= snap_eor;
      end
      if (eof) begin
        status_word <= pack_status(start ? snap_eor : frm_eor, flags, stored);
        status_err  <= err_summary(flags);
      end
    end
  end

  // R8: the reported length never exceeds the programmed maximum
  p_len_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && eof && max_len < 16'd16384) |=> ({2'b00, status_word[LEN_W-1:0]} <= $past(max_len)));
endmodule

// File: rtl/rx_desc_ring_engine.sv
module rx_desc_ring_engine #(
  parameter int AW       = 32,
  parameter int MAX_DESC = 1024,
  parameter int RUNT_LEN = 64,
  parameter int MW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic [15:0]   max_len,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic          rx_crc_err,
  input  logic          rx_fifo_ovf,
  input  logic          rx_bcast,
  input  logic          rx_phys_match,
  input  logic          rx_mcast,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [31:0]   mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [3:0]    mem_wr_be,
  output logic [31:0]   mem_wr_data,
  output logic [15:0]   irq_req,
  output logic [MW-1:0] missed_cnt
);
  import rde_pkg::*;

  localparam int IDX_W = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;

  rde_state_e    state_q, state_d;
  logic [AW-1:0] desc_addr, snap_buf, store_addr;
  logic          snap_vld, snap_own, snap_eor, frm_eor;
  logic          store_en, status_err, rdu_q;
  logic [31:0]   status_word;

  // named internal events
  logic in_poll, sof_seen, take, drop_go, byte_en, wb;
  assign in_poll  = (state_q == S_POLL_CTL) || (state_q == S_POLL_BUF) || (state_q == S_POLL_DONE);
  assign sof_seen = in_poll && rx_valid && rx_sof;
  assign take     = sof_seen && snap_vld && snap_own;
  assign drop_go  = sof_seen && !take;
  assign byte_en  = rx_valid && (take || state_q == S_FRAME);
  assign wb       = (state_q == S_WB);

  rde_ring_ptr #(.AW(AW), .MAX_DESC(MAX_DESC), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .rd_data(mem_rd_data),
    .cap_ctl(state_q == S_POLL_BUF), .commit(state_q == S_POLL_DONE),
    .advance(wb), .adv_eor(frm_eor), .desc_addr(desc_addr),
    .snap_vld(snap_vld), .snap_own(snap_own), .snap_eor(snap_eor), .snap_buf(snap_buf)
  );

  rde_frame_track #(.AW(AW), .RUNT_LEN(RUNT_LEN)) u_frm (
    .clk(clk), .rst_n(rst_n), .start(take), .byte_en(byte_en), .eof(rx_eof),
    .snap_buf(snap_buf), .snap_eor(snap_eor), .max_len(max_len),
    .rx_fifo_ovf(rx_fifo_ovf), .rx_crc_err(rx_crc_err), .rx_bcast(rx_bcast),
    .rx_phys_match(rx_phys_match), .rx_mcast(rx_mcast),
    .store_en(store_en), .store_addr(store_addr), .frm_eor(frm_eor),
    .status_word(status_word), .status_err(status_err)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_POLL_CTL:  state_d = S_POLL_BUF;
      S_POLL_BUF:  state_d = S_POLL_DONE;
      S_POLL_DONE: state_d = S_POLL_CTL;
      S_FRAME:     if (rx_valid && rx_eof) state_d = S_WB;
      S_DROP:      if (rx_valid && rx_eof) state_d = S_POLL_CTL;
      S_WB:        state_d = S_POLL_CTL;
      default:     state_d = S_POLL_CTL;
    endcase
    if (take)    state_d = rx_eof ? S_WB : S_FRAME;
    if (drop_go) state_d = rx_eof ? S_POLL_CTL : S_DROP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_POLL_CTL;
      rdu_q      <= 1'b0;
      missed_cnt <= '0;
    end else begin
      state_q <= state_d;
      rdu_q   <= drop_go;
      if (drop_go && missed_cnt != {MW{1'b1}}) missed_cnt <= missed_cnt + MW'(1);
    end
  end

  assign mem_rd_en   = (state_q == S_POLL_CTL) || (state_q == S_POLL_BUF);
  assign mem_rd_addr = (state_q == S_POLL_BUF) ? desc_addr + AW'(4) : desc_addr;

  assign mem_wr_en   = wb || store_en;
  assign mem_wr_addr = wb ? desc_addr : {store_addr[AW-1:2], 2'b00};
  assign mem_wr_be   = wb ? 4'hF : (4'b0001 << store_addr[1:0]);
  assign mem_wr_data = wb ? status_word : {4{rx_data}};

  always_comb begin
    irq_req          = '0;
    irq_req[IRQ_ROK] = wb && !status_err;
    irq_req[IRQ_RER] = wb && status_err;
    irq_req[IRQ_RDU] = rdu_q;
  end

  // R10: a dropped frame touches no memory
  p_no_store_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DROP) |-> !mem_wr_en);
  // R4: write-back hands the descriptor back with both segment flags
  p_wb_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb |-> (mem_wr_en && !mem_wr_data[ST_OWN] && mem_wr_data[ST_FS] && mem_wr_data[ST_LS]));
  // R9: at most one request kind per cycle
  p_irq_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_req[IRQ_RDU], irq_req[IRQ_RER], irq_req[IRQ_ROK]}));
  // R10: each unavailable pulse matches one step of the missed count
  p_missed_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req[IRQ_RDU] && $past(missed_cnt) != {MW{1'b1}}) |-> (missed_cnt == $past(missed_cnt) + MW'(1)));
  // R3: a data byte lands in exactly one lane
  p_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !wb) |-> $onehot(mem_wr_be));
  // R5: write-back is a single cycle and polling resumes
  p_wb_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb |=> (state_q == S_POLL_CTL));
endmodule

// File: tb/rx_desc_ring_engine_test.sv
module rx_desc_ring_engine_test;
  localparam int AW = 32;
  localparam int MW = 16;
  localparam logic [15:0] MAXL = 16'd100;

  // [22:7] length, [6] crc, [5] fifo ovf, [4] bcast, [3] phys, [2] mcast, [1] expect receive OK
  localparam logic [22:0] VEC [8] = '{
    {16'd70,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {16'd64,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'd63,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'd70,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'd80,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'd120, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'd100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {16'd70,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] ring_base;
  logic [15:0]   max_len;
  logic          rx_valid, rx_sof, rx_eof, rx_crc_err, rx_fifo_ovf;
  logic          rx_bcast, rx_phys_match, rx_mcast;
  logic [7:0]    rx_data;
  logic          mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [31:0]   mem_rd_data, mem_wr_data;
  logic [3:0]    mem_wr_be;
  logic [15:0]   irq_req;
  logic [MW-1:0] missed_cnt;

  rx_desc_ring_engine #(.AW(AW), .MW(MW)) uut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .max_len(max_len),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_crc_err(rx_crc_err), .rx_fifo_ovf(rx_fifo_ovf), .rx_bcast(rx_bcast),
    .rx_phys_match(rx_phys_match), .rx_mcast(rx_mcast),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_be(mem_wr_be),
    .mem_wr_data(mem_wr_data), .irq_req(irq_req), .missed_cnt(missed_cnt)
  );

  // host memory model: one read port with one cycle latency, byte-enabled writes
  logic [31:0] mem [512];
  logic        host_we;
  logic [10:0] host_addr;
  logic [31:0] host_data;

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[10:2]];
    if (mem_wr_en)
      for (int b = 0; b < 4; b++)
        if (mem_wr_be[b]) mem[mem_wr_addr[10:2]][8*b +: 8] <= mem_wr_data[8*b +: 8];
    if (host_we) mem[host_addr[10:2]] <= host_data;
  end

  int n_checks = 0, n_errors = 0;
  int n_rok = 0, n_rer = 0, n_rdu = 0;
  bit done = 0;

  always @(negedge clk) if (rst_n) begin
    if (irq_req[0]) n_rok++;
    if (irq_req[1]) n_rer++;
    if (irq_req[4]) n_rdu++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  task automatic host_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    host_we = 1'b1; host_addr = 11'(addr); host_data = data;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(k * 7 + seed * 13 + 1);
  endfunction

  function automatic logic [7:0] mem_byte(input int a);
    return mem[a >> 2][8 * (a % 4) +: 8];
  endfunction

  task automatic fill_buf(input int base);
    for (int w = 0; w < 64; w++) host_write(base + 4 * w, 32'hEEEE_EEEE);
  endtask

  task automatic send_frame(input int len, input bit crc, input int ovf_at,
                            input bit bc, input bit pm, input bit mc, input int seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pat(seed, k);
      rx_sof = (k == 0); rx_eof = (k == len - 1);
      rx_fifo_ovf = (k == ovf_at);
      rx_crc_err = (k == len - 1) && crc;
      rx_bcast = (k == len - 1) && bc;
      rx_phys_match = (k == len - 1) && pm;
      rx_mcast = (k == len - 1) && mc;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_fifo_ovf = 0; rx_crc_err = 0;
    rx_bcast = 0; rx_phys_match = 0; rx_mcast = 0;
    repeat (12) @(negedge clk);
  endtask

  // status expected from R4..R8, built field by field
  function automatic logic [31:0] exp_status(input bit eor, input int len, input bit crc,
                                             input bit fovf, input bit bc, input bit pm, input bit mc);
    int stored;
    bit bovf, runt, res;
    logic [31:0] s;
    bovf = len > int'(MAXL);
    stored = bovf ? int'(MAXL) : len;
    runt = len < 64;
    res = crc || runt || fovf || bovf;
    s = 32'(stored) & 32'h3FFF;
    if (eor)  s = s | 32'h4000_0000;
    s = s | 32'h3000_0000;
    if (mc)   s = s | (32'h1 << 27);
    if (pm)   s = s | (32'h1 << 26);
    if (bc)   s = s | (32'h1 << 25);
    if (bovf) s = s | (32'h1 << 24);
    if (fovf) s = s | (32'h1 << 23);
    if (res)  s = s | (32'h1 << 21);
    if (runt) s = s | (32'h1 << 20);
    if (crc)  s = s | (32'h1 << 19);
    return s;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; ring_base = '0; max_len = MAXL; host_we = 0; host_addr = '0; host_data = '0;
    rx_valid = 0; rx_data = '0; rx_sof = 0; rx_eof = 0; rx_crc_err = 0; rx_fifo_ovf = 0;
    rx_bcast = 0; rx_phys_match = 0; rx_mcast = 0;
    for (int i = 0; i < 512; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    chk("R1", "wr_en in reset", 32'(mem_wr_en), 32'h0);
    chk("R1", "irq in reset", 32'(irq_req), 32'h0);
    chk("R1", "missed in reset", 32'(missed_cnt), 32'h0);
    rst_n = 1;
    #1;
    chk("R2", "first poll ctl addr", {31'(mem_rd_addr), mem_rd_en}, {31'h0, 1'b1});
    @(negedge clk);
    chk("R2", "first poll buf addr", {31'(mem_rd_addr), mem_rd_en}, {31'h4, 1'b1});
    chk("R1", "no write after reset", 32'(mem_wr_en), 32'h0);

    // four descriptors, last one marks ring end
    for (int d = 0; d < 4; d++) begin
      host_write(8 * d + 4, 32'(256 * (d + 1)));
      host_write(8 * d, (d == 3) ? 32'hC000_0000 : 32'h8000_0000);
    end

    for (int i = 0; i < 8; i++) begin
      int d, bufa, len, stored, mism, r0, e0;
      bit crc, fovf, bc, pm, mc, eok;
      logic [31:0] st;
      d = i % 4; bufa = 256 * (d + 1);
      len = int'(VEC[i][22:7]); crc = VEC[i][6]; fovf = VEC[i][5];
      bc = VEC[i][4]; pm = VEC[i][3]; mc = VEC[i][2]; eok = VEC[i][1];
      fill_buf(bufa);
      repeat (6) @(negedge clk);
      r0 = n_rok; e0 = n_rer;
      send_frame(len, crc, fovf ? 40 : -1, bc, pm, mc, i);
      st = mem[2 * d];
      chk("R4 R6 R7 R8", $sformatf("status frame %0d", i), st, exp_status(d == 3, len, crc, fovf, bc, pm, mc));
      if (d == 3) chk("R5", "end-of-ring kept", 32'(st[30]), 32'h1);
      chk("R9", $sformatf("irq ok/err frame %0d", i), {30'h0, 1'(n_rok - r0), 1'(n_rer - e0)}, {30'h0, eok, !eok});
      stored = (len > int'(MAXL)) ? int'(MAXL) : len;
      mism = 0;
      for (int k = 0; k < stored; k++) if (mem_byte(bufa + k) !== pat(i, k)) mism++;
      chk("R3", $sformatf("buffer bytes frame %0d", i), 32'(mism), 32'h0);
      chk("R8", $sformatf("byte past end frame %0d", i), 32'(mem_byte(bufa + stored)), 32'hEE);
      host_write(8 * d, (d == 3) ? 32'hC000_0000 : 32'h8000_0000);
    end

    // descriptor 0 is current again after the wrap; withhold it
    begin
      int u0, r0, e0;
      host_write(0, 32'h0);
      fill_buf(256);
      repeat (8) @(negedge clk);
      u0 = n_rdu; r0 = n_rok; e0 = n_rer;
      send_frame(70, 0, -1, 0, 1, 0, 9);
      chk("R10", "unavailable pulse", 32'(n_rdu - u0), 32'h1);
      chk("R10", "missed count", 32'(missed_cnt), 32'h1);
      chk("R10", "no write-back", mem[0], 32'h0);
      chk("R10", "buffer untouched", 32'(mem_byte(256)), 32'hEE);
      chk("R10", "no ok/err pulse", 32'((n_rok - r0) + (n_rer - e0)), 32'h0);

      host_write(0, 32'h8000_0000);
      repeat (8) @(negedge clk);
      r0 = n_rok;
      send_frame(66, 0, -1, 0, 1, 0, 11);
      chk("R11", "stored after ownership returned", mem[0], exp_status(0, 66, 0, 0, 0, 1, 0));
      chk("R11", "first byte", 32'(mem_byte(256)), 32'(pat(11, 0)));
      chk("R9", "ok pulse after release", 32'(n_rok - r0), 32'h1);
      chk("R10", "missed unchanged", 32'(missed_cnt), 32'h1);
    end

    finish_run();
  end
endmodule